// File: doc/BRIEF.md
# Board Interrupt Expander

This block gathers sixteen external interrupt request lines from a board and presents them to a host processor as one active-high, level-sensitive summary interrupt. Every line is brought into the clock domain through a two-stage synchronizer. The block then records it in a sticky status bit. The host clears that bit by writing a one to it. A separate per-line enable mask decides which recorded lines may raise the summary output. Two peripheral serial ports drive lines 10 and 11. The remaining lines are free for other board sources.

The host reaches the block through a simple synchronous 16-bit register port. The port has an address, a write strobe, a read strobe and separate write and read data buses. The mask has two addresses. Writing ones to the set address enables lines. Writing ones to the clear address disables them. Reading either address returns the mask. A further address returns the live synchronized input levels, with no latching. Two small state machines run the port and the summary output. The access machine has the states ACC_IDLE and ACC_RESP. It moves to ACC_RESP in any cycle with the read strobe high and returns to ACC_IDLE otherwise. The summary machine has the states SUM_QUIET and SUM_RAISED. It moves to SUM_RAISED while any enabled status bit is set and falls back to SUM_QUIET when none is set.

Register offsets (byte addresses): 0x16 latched status (write one to clear), 0x18 live levels (read only), 0x1A mask set, 0x1C mask clear.

Top module: `irq_expander`

## Requirements
- R1: After reset the status, the mask, the read data and irq_out are all zero.
- R2: A line held high at the input sets its status bit on the third rising clock edge after the change: two synchronizer edges, then the latch edge. The bit is set whether or not the line is enabled, and it stays set after the input falls.
- R3: Writing to offset 0x16 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a clear at offset 0x16 and a still-high synchronized input hit the same bit in the same cycle, the bit stays set.
- R5: A read at offset 0x18 returns the synchronized live input levels, one bit per line, with bit n for line n.
- R6: Writing to offset 0x1A sets each mask bit whose write-data bit is 1, and other bits are kept. A read returns the mask, where 1 means enabled.
- R7: Writing to offset 0x1C clears each mask bit whose write-data bit is 1. A read at 0x1C returns the mask and changes nothing.
- R8: irq_out is high on the clock cycle after any bit of (status AND mask) is set. It is low on the cycle after none is set.
- R9: Reads from any other offset return zero, and writes to them change neither status nor mask.
- R10: Read data appears on rdata in the cycle after the read strobe. rdata is zero in any cycle that does not follow a read strobe.
- R11: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with all inputs low, leaves every mask bit and every status bit clear and irq_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Asynchronous interrupt request inputs, bit n is line n |
| addr | input | 8 | Byte offset of the register being accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after rd_en |
| irq_out | output | 1 | Active-high level summary interrupt |

## Verification
A wrong status or mask bit shows up within one cycle as a wrong irq_out level, and in the next read of 0x16 or 0x1A. A synchronizer with a stage added or dropped moves the cycle in which the status bit first reads back as set. The bench catches this by reading status exactly at the boundary edge. A mask or status that drifts on an ignored access is caught by read-back right after the access. A stuck access state shows up as nonzero rdata in a cycle with no preceding read.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    parameter int OFS_STATUS = 'h16;
    parameter int OFS_LIVE   = 'h18;
    parameter int OFS_MSET   = 'h1A;
    parameter int OFS_MCLR   = 'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_LIVE,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    typedef enum logic {
        ACC_IDLE,
        ACC_RESP
    } acc_state_e;

    typedef enum logic {
        SUM_QUIET,
        SUM_RAISED
    } sum_state_e;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] sync_lvl,
    input  logic [LINES-1:0] clr_status,
    input  logic [LINES-1:0] set_mask,
    input  logic [LINES-1:0] clr_mask,
    output logic [LINES-1:0] status_q,
    output logic [LINES-1:0] mask_q
);
    logic [LINES-1:0] status_d;
    logic [LINES-1:0] mask_d;

    // A set from a high input overrides a clear in the same cycle.
    always_comb begin
        status_d = (status_q & ~clr_status) | sync_lvl;
        mask_d   = (mask_q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end
endmodule

// File: rtl/irqx_host_port.sv
module irqx_host_port
    import irqx_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  status_q,
    input  logic [LINES-1:0]  mask_q,
    input  logic [LINES-1:0]  live_lvl,
    output logic [LINES-1:0]  rdata,
    output logic [LINES-1:0]  clr_status,
    output logic [LINES-1:0]  set_mask,
    output logic [LINES-1:0]  clr_mask
);
    reg_sel_e         sel;
    acc_state_e       acc_q;
    acc_state_e       acc_d;
    logic [LINES-1:0] rd_mux;
    logic [LINES-1:0] rdata_q;

    always_comb begin
        if      (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFS_LIVE))   sel = SEL_LIVE;
        else if (addr == ADDR_W'(OFS_MSET))   sel = SEL_MSET;
        else if (addr == ADDR_W'(OFS_MCLR))   sel = SEL_MCLR;
        else                                  sel = SEL_NONE;
    end

    always_comb begin
        rd_mux     = '0;
        clr_status = '0;
        set_mask   = '0;
        clr_mask   = '0;
        unique case (sel)
            SEL_STATUS: begin
                rd_mux     = status_q;
                clr_status = wr_en ? wdata : '0;
            end
            SEL_LIVE:   rd_mux = live_lvl;
            SEL_MSET: begin
                rd_mux   = mask_q;
                set_mask = wr_en ? wdata : '0;
            end
            SEL_MCLR: begin
                rd_mux   = mask_q;
                clr_mask = wr_en ? wdata : '0;
            end
            default:    rd_mux = '0;
        endcase
    end

    // Access state machine: ACC_RESP marks the cycle after a read strobe.
    always_comb begin
        unique case (acc_q)
            ACC_IDLE: acc_d = rd_en ? ACC_RESP : ACC_IDLE;
            ACC_RESP: acc_d = rd_en ? ACC_RESP : ACC_IDLE;
            default:  acc_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ACC_IDLE;
        else        acc_q <= acc_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = (acc_q == ACC_RESP) ? rdata_q : '0;
endmodule

// File: rtl/irqx_summary.sv
module irqx_summary
    import irqx_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] status_q,
    input  logic [LINES-1:0] mask_q,
    output logic             irq_out
);
    sum_state_e sum_q;
    sum_state_e sum_d;
    logic       pending;

    assign pending = |(status_q & mask_q);

    always_comb begin
        unique case (sum_q)
            SUM_QUIET:  sum_d = pending ? SUM_RAISED : SUM_QUIET;
            SUM_RAISED: sum_d = pending ? SUM_RAISED : SUM_QUIET;
            default:    sum_d = SUM_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= SUM_QUIET;
        else        sum_q <= sum_d;
    end

    always_comb begin
        irq_out = (sum_q == SUM_RAISED);
    end
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
    parameter int LINES       = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LINES-1:0]  wdata,
    output logic [LINES-1:0]  rdata,
    output logic              irq_out
);
    logic [LINES-1:0] sync_lvl;
    logic [LINES-1:0] status_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] clr_status;
    logic [LINES-1:0] set_mask;
    logic [LINES-1:0] clr_mask;

    irqx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_lines),
        .dout (sync_lvl)
    );

    irqx_core #(.LINES(LINES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_lvl  (sync_lvl),
        .clr_status(clr_status),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .status_q  (status_q),
        .mask_q    (mask_q)
    );

    irqx_host_port #(.LINES(LINES), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .live_lvl  (sync_lvl),
        .rdata     (rdata),
        .clr_status(clr_status),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask)
    );

    irqx_summary #(.LINES(LINES)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .status_q(status_q),
        .mask_q  (mask_q),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker
    import irqx_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [LINES-1:0]  rdata,
    input logic              irq_out,
    input logic [LINES-1:0]  status_q,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  sync_lvl
);
    logic mapped;
    assign mapped = (addr == ADDR_W'(OFS_STATUS)) || (addr == ADDR_W'(OFS_LIVE)) ||
                    (addr == ADDR_W'(OFS_MSET))   || (addr == ADDR_W'(OFS_MCLR));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask_q)) |=> irq_out);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & mask_q)) |=> !irq_out);

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl != '0) |=> ((status_q & $past(sync_lvl)) == $past(sync_lvl)));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> $stable(mask_q));
endmodule

bind irq_expander irqx_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq_out (irq_out),
    .status_q(status_q),
    .mask_q  (mask_q),
    .sync_lvl(sync_lvl)
);

// File: tb/test_irq_expander.sv
`timescale 1ns/1ps
module test_irq_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic     rd_pend = 1'b0;

    always #5 clk = ~clk;

    irq_expander i_irq_expander (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // Monitor: a read strobe seen at an edge yields data checked at the next falling edge.
    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected read response actual=%h expected=none", rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_bit(input logic act, input logic e, input string tag);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check_bit(irq_out, 1'b0, "R1 irq_out after reset");
        bus_read(8'h16, 16'h0000, "R1 status after reset");
        bus_read(8'h1A, 16'h0000, "R1 mask after reset");
        // R10: no read strobe in previous cycle -> zero
        idle(1);
        total++;
        if (rdata !== 16'h0000) begin
            bad++; $display("FAIL R10 idle rdata actual=%h expected=0000", rdata);
        end

        // R2: line 10 latency and latching with mask off
        irq_lines[10] = 1'b1;
        idle(2);
        bus_read(8'h16, 16'h0000, "R2 status before third edge");
        bus_read(8'h16, 16'h0400, "R2 status at third edge");
        // R5: live view
        bus_read(8'h18, 16'h0400, "R5 live level high");
        check_bit(irq_out, 1'b0, "R8 masked line keeps irq low");
        irq_lines[10] = 1'b0;
        idle(3);
        bus_read(8'h18, 16'h0000, "R5 live level low");
        bus_read(8'h16, 16'h0400, "R2 status sticky after input falls");

        // R3: write-one-to-clear
        bus_write(8'h16, 16'h0000);
        bus_read(8'h16, 16'h0400, "R3 zero write keeps status");
        bus_write(8'h16, 16'hFBFF);
        bus_read(8'h16, 16'h0400, "R3 other bits write keeps status");
        bus_write(8'h16, 16'h0400);
        bus_read(8'h16, 16'h0000, "R3 clear line 10");

        // R4: clear while line 11 still high
        irq_lines[11] = 1'b1;
        idle(4);
        bus_write(8'h16, 16'h0800);
        bus_read(8'h16, 16'h0800, "R4 set wins over clear");
        irq_lines[11] = 1'b0;
        idle(3);
        bus_write(8'h16, 16'h0800);
        bus_read(8'h16, 16'h0000, "R4 clear after input low");

        // R6: mask set accumulates
        bus_write(8'h1A, 16'h0C00);
        bus_read(8'h1A, 16'h0C00, "R6 mask after set");
        bus_write(8'h1A, 16'h0001);
        bus_read(8'h1A, 16'h0C01, "R6 mask set keeps others");
        bus_read(8'h1C, 16'h0C01, "R7 read of clear address");
        bus_read(8'h1C, 16'h0C01, "R7 repeated read harmless");

        // R8: one-cycle pulse on line 10, irq timing
        irq_lines[10] = 1'b1;
        @(negedge clk);
        irq_lines[10] = 1'b0;
        idle(2);
        check_bit(irq_out, 1'b0, "R8 irq low at latch edge");
        idle(1);
        check_bit(irq_out, 1'b1, "R8 irq high cycle after");

        // R7: mask clear drops irq, status kept
        bus_write(8'h1C, 16'h0400);
        idle(1);
        check_bit(irq_out, 1'b0, "R7 irq low after mask clear");
        bus_read(8'h1A, 16'h0801, "R7 mask after clear");
        bus_read(8'h16, 16'h0400, "R2 status kept while disabled");
        bus_write(8'h1A, 16'h0400);
        idle(1);
        check_bit(irq_out, 1'b1, "R8 irq high after re-enable");

        // R9: unmapped offsets
        bus_write(8'h00, 16'hFFFF);
        bus_write(8'h1E, 16'hFFFF);
        bus_read(8'h1A, 16'h0C01, "R9 mask after unmapped writes");
        bus_read(8'h16, 16'h0400, "R9 status after unmapped writes");
        bus_read(8'h00, 16'h0000, "R9 read offset 0x00");
        bus_read(8'h1E, 16'h0000, "R9 read offset 0x1E");

        // R11: full disable then full clear
        irq_lines[0] = 1'b1;
        @(negedge clk);
        irq_lines[0] = 1'b0;
        idle(4);
        bus_write(8'h1C, 16'hFFFF);
        bus_write(8'h16, 16'hFFFF);
        bus_read(8'h1A, 16'h0000, "R11 mask all clear");
        bus_read(8'h16, 16'h0000, "R11 status all clear");
        idle(1);
        check_bit(irq_out, 1'b0, "R11 irq low");

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule